// File: doc/BRIEF.md
# Fail-on-First Element Sequencer

This block walks the elements of one vector operation in strict index order, from element 0 up to the vector length, under a predicate mask. For each element whose mask bit is set it issues one element request to an external datapath and waits for the matching response. A response carries a result word and a fault flag. Only one request is outstanding at a time. Requests and responses each use a valid/ready handshake.

With fail-first enabled, the sequence can end early, depending on the data. Two variants exist. In the fault variant, a fault on any element after the first active one stops the loop. In the zero variant, a result equal to zero stops the loop. In floating-point mode a negative zero also counts as zero. When the loop ends early, the block reports the index of the stopping element as the new, truncated vector length. A fault that cannot be absorbed this way raises a trap and reports the faulting index instead. This covers a fault on the first active element, any fault while fail-first is off, and any fault in the zero variant.

Masked-off elements are skipped. If zeroing is on, each masked-off element instead gets a zero-write request, and the response to that request is never examined. An all-ones mask makes every element active.

Top module: `ffirst_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `trap`, `req_valid` and `rsp_ready` are 0 and `new_vl` is 0.
- R2: Requests are issued in strictly increasing element index, all below the latched length, with at most one outstanding; while `req_ready` is 0, `req_valid` stays 1 and `req_idx` stays unchanged.
- R3: An element whose mask bit (bit i of `mask` for element i) is 0 gets no request when `zeroing` is 0, and one request with `req_zero`=1 when `zeroing` is 1; the response to a `req_zero` request never stops the sequence, whatever its data or fault.
- R4: With `ffirst_en`=0, and with no fault, every element up to `vlen` is visited, and the block finishes with `new_vl`=`vlen` and `trap`=0, even if results are zero.
- R5: A fault seen with `ffirst_en`=0, or with `zero_mode`=1, ends the sequence with `trap`=1 and `new_vl` equal to the faulting element index.
- R6: In the fault variant (`ffirst_en`=1, `zero_mode`=0), a fault on the first active element traps with `new_vl` equal to its index; a fault on a later active element ends the sequence with `trap`=0 and `new_vl` equal to its index.
- R7: In the zero variant (`ffirst_en`=1, `zero_mode`=1), a zero result on an active element ends the sequence with `trap`=0 and `new_vl` equal to its index, including index 0. Zero means all `rsp_data` bits are 0 when `fp_mode`=0. It means all bits except the top (sign) bit are 0 when `fp_mode`=1.
- R8: `done` is a one-cycle pulse, `trap` is 1 only together with `done`, and `new_vl` never exceeds the latched length. A length of 0 finishes with `new_vl`=0 and no request.
- R9: `start` while `busy` is 1 is ignored: the running sequence and its latched length, mask and modes are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence; sampled only while idle |
| vlen | input | $clog2(MAXVL+1) | Vector length, clamped to MAXVL |
| mask | input | MAXVL | Predicate mask, bit i for element i |
| ffirst_en | input | 1 | Enable fail-first truncation |
| zero_mode | input | 1 | 0: fault variant, 1: zero-result variant |
| fp_mode | input | 1 | Treat results as floating point for the zero test |
| zeroing | input | 1 | Issue zero-write requests for masked-off elements |
| req_valid | output | 1 | Element request valid |
| req_ready | input | 1 | Datapath accepts the request |
| req_idx | output | $clog2(MAXVL) | Element index of the request |
| req_zero | output | 1 | Request is a zero-write for a masked-off element |
| rsp_valid | input | 1 | Element response valid |
| rsp_ready | output | 1 | Block waits for a response |
| rsp_data | input | DW | Element result |
| rsp_fault | input | 1 | Element raised a fault |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse: sequence ended |
| trap | output | 1 | With done: the sequence ended on a trap |
| new_vl | output | $clog2(MAXVL+1) | Truncated length, or faulting index on a trap |

## Verification
The assertions assume that the datapath answers only while `rsp_ready` is high, and that `vlen` does not exceed MAXVL. They also assume the configuration inputs matter only in the cycle `start` is taken. The bench stimulus respects all three. Its responder drives `rsp_valid` only in a cycle where it has seen `rsp_ready`, and drops it right after the handshake. Each case uses a length of at most eight. A second `start` pulse is issued only in the directed test meant to show that it is ignored, and there it is issued with deliberately different values.

// File: rtl/ffirst_seq.sv
module ffirst_seq #(
  parameter int MAXVL = 8,
  parameter int DW    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [$clog2(MAXVL+1)-1:0] vlen,
  input  logic [MAXVL-1:0]           mask,
  input  logic                       ffirst_en,
  input  logic                       zero_mode,
  input  logic                       fp_mode,
  input  logic                       zeroing,
  output logic                       req_valid,
  input  logic                       req_ready,
  output logic [$clog2(MAXVL)-1:0]   req_idx,
  output logic                       req_zero,
  input  logic                       rsp_valid,
  output logic                       rsp_ready,
  input  logic [DW-1:0]              rsp_data,
  input  logic                       rsp_fault,
  output logic                       busy,
  output logic                       done,
  output logic                       trap,
  output logic [$clog2(MAXVL+1)-1:0] new_vl
);
  localparam int IW = $clog2(MAXVL);
  localparam int LW = $clog2(MAXVL + 1);

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_REQ, S_WAIT} st_t;

  st_t            st;
  logic [LW-1:0]  idx_q, vl_q, nvl_q;
  logic [MAXVL-1:0] mask_q;
  logic           ff_q, zvar_q, fp_q, zer_q;
  logic           any_q, zreq_q, done_q, trap_q;

  logic at_end, cur_on, is_zero, trap_hit, cut_hit;

  assign at_end  = (idx_q == vl_q);
  assign cur_on  = mask_q[idx_q[IW-1:0]];
  assign is_zero = fp_q ? (rsp_data[DW-2:0] == '0) : (rsp_data == '0);
  assign trap_hit = !zreq_q && rsp_fault && (!ff_q || zvar_q || !any_q);
  assign cut_hit  = !zreq_q && ff_q &&
                    ((!zvar_q && rsp_fault && any_q) ||
                     (zvar_q && !rsp_fault && is_zero));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      idx_q  <= '0;
      vl_q   <= '0;
      nvl_q  <= '0;
      mask_q <= '0;
      ff_q   <= 1'b0;
      zvar_q <= 1'b0;
      fp_q   <= 1'b0;
      zer_q  <= 1'b0;
      any_q  <= 1'b0;
      zreq_q <= 1'b0;
      done_q <= 1'b0;
      trap_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      trap_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          vl_q   <= (vlen > LW'(MAXVL)) ? LW'(MAXVL) : vlen;
          mask_q <= mask;
          ff_q   <= ffirst_en;
          zvar_q <= zero_mode;
          fp_q   <= fp_mode;
          zer_q  <= zeroing;
          idx_q  <= '0;
          any_q  <= 1'b0;
          st     <= S_SCAN;
        end
        S_SCAN: begin
          if (at_end) begin
            done_q <= 1'b1;
            nvl_q  <= vl_q;
            st     <= S_IDLE;
          end else if (cur_on || zer_q) begin
            zreq_q <= !cur_on;
            st     <= S_REQ;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        S_REQ: if (req_ready) st <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          if (trap_hit || cut_hit) begin
            done_q <= 1'b1;
            trap_q <= trap_hit;
            nvl_q  <= idx_q;
            st     <= S_IDLE;
          end else begin
            any_q <= any_q | !zreq_q;
            idx_q <= idx_q + 1'b1;
            st    <= S_SCAN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_valid = (st == S_REQ);
  assign req_idx   = idx_q[IW-1:0];
  assign req_zero  = zreq_q;
  assign rsp_ready = (st == S_WAIT);
  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign trap      = trap_q;
  assign new_vl    = nvl_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_idx));   // R2
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> LW'(req_idx) < vl_q);                           // R2
  AST_SINGLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));                                   // R2
  AST_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !mask_q[req_idx] |-> req_zero);                  // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                              // R8
  AST_TRAP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> done);                                               // R8
  AST_VL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> new_vl <= vl_q);                                     // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> vl_q == $past(vl_q) && mask_q == $past(mask_q)); // R9
endmodule

// File: tb/ffirst_seq_bench.sv
module ffirst_seq_bench;
  localparam int MAXVL = 8;
  localparam int DW    = 32;
  localparam int LW    = $clog2(MAXVL + 1);
  localparam int IW    = $clog2(MAXVL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             start = 1'b0;
  logic [LW-1:0]    vlen = '0;
  logic [MAXVL-1:0] mask = '0;
  logic             ffirst_en = 1'b0, zero_mode = 1'b0, fp_mode = 1'b0, zeroing = 1'b0;
  logic             req_valid, req_ready = 1'b1, req_zero, rsp_ready;
  logic [IW-1:0]    req_idx;
  logic             rsp_valid = 1'b0, rsp_fault = 1'b0;
  logic [DW-1:0]    rsp_data = '0;
  logic             busy, done, trap;
  logic [LW-1:0]    new_vl;

  ffirst_seq #(.MAXVL(MAXVL), .DW(DW)) u_ffirst_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen), .mask(mask),
    .ffirst_en(ffirst_en), .zero_mode(zero_mode), .fp_mode(fp_mode), .zeroing(zeroing),
    .req_valid(req_valid), .req_ready(req_ready), .req_idx(req_idx), .req_zero(req_zero),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_fault(rsp_fault),
    .busy(busy), .done(done), .trap(trap), .new_vl(new_vl));

  typedef struct packed {
    logic [3:0] vl;
    logic [7:0] msk;
    logic       ff, zv, fp, zer;
    logic [3:0] fault_at, zero_at;
    logic       negz;
    logic [3:0] e_vl;
    logic       e_trap;
    logic [3:0] e_nreq, e_nzero;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{4'd8, 8'hFF, 1'b0,1'b0,1'b0,1'b0, 4'd15,4'd15,1'b0, 4'd8,1'b0,4'd8,4'd0}, // R4 full
    '{4'd5, 8'h16, 1'b0,1'b0,1'b0,1'b0, 4'd15,4'd15,1'b0, 4'd5,1'b0,4'd3,4'd0}, // R3 skip
    '{4'd5, 8'h16, 1'b0,1'b0,1'b0,1'b1, 4'd15,4'd15,1'b0, 4'd5,1'b0,4'd5,4'd2}, // R3 zeroing
    '{4'd8, 8'hFF, 1'b1,1'b0,1'b0,1'b0, 4'd3, 4'd15,1'b0, 4'd3,1'b0,4'd4,4'd0}, // R6 cut
    '{4'd8, 8'hFF, 1'b1,1'b0,1'b0,1'b0, 4'd0, 4'd15,1'b0, 4'd0,1'b1,4'd1,4'd0}, // R6 first
    '{4'd8, 8'hFC, 1'b1,1'b0,1'b0,1'b0, 4'd2, 4'd15,1'b0, 4'd2,1'b1,4'd1,4'd0}, // R6 first active
    '{4'd8, 8'hFF, 1'b0,1'b0,1'b0,1'b0, 4'd5, 4'd15,1'b0, 4'd5,1'b1,4'd6,4'd0}, // R5 no ffirst
    '{4'd8, 8'hFF, 1'b1,1'b1,1'b0,1'b0, 4'd15,4'd4, 1'b0, 4'd4,1'b0,4'd5,4'd0}, // R7 int zero
    '{4'd8, 8'hFF, 1'b1,1'b1,1'b0,1'b0, 4'd15,4'd0, 1'b0, 4'd0,1'b0,4'd1,4'd0}, // R7 zero at 0
    '{4'd8, 8'hFF, 1'b0,1'b1,1'b0,1'b0, 4'd15,4'd2, 1'b0, 4'd8,1'b0,4'd8,4'd0}, // R4 zero ignored
    '{4'd8, 8'hFF, 1'b1,1'b1,1'b1,1'b0, 4'd15,4'd3, 1'b1, 4'd3,1'b0,4'd4,4'd0}, // R7 fp neg zero
    '{4'd8, 8'hFF, 1'b1,1'b1,1'b0,1'b0, 4'd15,4'd3, 1'b1, 4'd8,1'b0,4'd8,4'd0}, // R7 int sign bit
    '{4'd8, 8'hFB, 1'b1,1'b1,1'b0,1'b1, 4'd15,4'd2, 1'b0, 4'd8,1'b0,4'd8,4'd1}, // R3 zero-write
    '{4'd8, 8'hFF, 1'b1,1'b1,1'b0,1'b0, 4'd6, 4'd15,1'b0, 4'd6,1'b1,4'd7,4'd0}, // R5 zero variant
    '{4'd0, 8'hFF, 1'b1,1'b0,1'b0,1'b0, 4'd15,4'd15,1'b0, 4'd0,1'b0,4'd0,4'd0}, // R8 empty
    '{4'd6, 8'hF0, 1'b1,1'b0,1'b0,1'b0, 4'd5, 4'd15,1'b0, 4'd5,1'b0,4'd2,4'd0}  // R6 late
  };

  int errors = 0, checks = 0;
  int nreq, nzero, last_idx, order_bad;
  logic got_trap;
  logic [LW-1:0] got_vl;
  logic finished;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic launch(input vec_t v);
    @(negedge clk);
    vlen = v.vl; mask = v.msk; ffirst_en = v.ff; zero_mode = v.zv;
    fp_mode = v.fp; zeroing = v.zer;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic respond(input vec_t v);
    nreq = 0; nzero = 0; last_idx = -1; order_bad = 0; finished = 1'b0;
    for (int i = 0; i < 200 && !finished; i++) begin
      if (i != 0) @(negedge clk);
      if (done) begin
        finished = 1'b1; got_vl = new_vl; got_trap = trap;
      end else begin
        if (req_valid && req_ready) begin
          nreq++;
          if (req_zero) nzero++;
          if (int'(req_idx) <= last_idx) order_bad++;
          last_idx = int'(req_idx);
        end
        if (rsp_ready) begin
          rsp_valid = 1'b1;
          rsp_fault = (int'(req_idx) == int'(v.fault_at));
          if (int'(req_idx) == int'(v.zero_at)) rsp_data = v.negz ? 32'h8000_0000 : 32'h0;
          else rsp_data = 32'h100 + DW'(req_idx);
          @(posedge clk); #1;
          rsp_valid = 1'b0; rsp_fault = 1'b0;
        end
      end
    end
    if (!finished) begin
      got_vl = '1; got_trap = 1'bx;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R8 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 trap", trap, 0);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 rsp_ready", rsp_ready, 0);
    chk("R1 new_vl", new_vl, 0);

    for (int k = 0; k < NV; k++) begin
      launch(TBL[k]);
      respond(TBL[k]);
      chk($sformatf("case %0d finished R8", k), finished, 1);
      chk($sformatf("case %0d new_vl R4 R5 R6 R7", k), got_vl, TBL[k].e_vl);
      chk($sformatf("case %0d trap R5 R6", k), got_trap, TBL[k].e_trap);
      chk($sformatf("case %0d requests R2 R3", k), nreq, TBL[k].e_nreq);
      chk($sformatf("case %0d zero-writes R3", k), nzero, TBL[k].e_nzero);
      chk($sformatf("case %0d order R2", k), order_bad, 0);
      @(negedge clk);
      chk($sformatf("case %0d done pulse R8", k), done, 0);
    end

    // R2 back-pressure hold and R9 start while busy
    req_ready = 1'b0;
    launch(TBL[0]);
    vlen = 4'd2; mask = 8'h00; ffirst_en = 1'b1; zero_mode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 3; c++) begin
      chk("R2 req held", req_valid, 1);
      chk("R2 idx held", req_idx, 0);
      @(negedge clk);
    end
    req_ready = 1'b1;
    respond(TBL[0]);
    chk("R9 new_vl after ignored start", got_vl, 8);
    chk("R9 requests after ignored start", nreq, 8);
    chk("R9 trap", got_trap, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule